// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller

This block sequences a successive-approximation analog-to-digital conversion. It never touches an analog signal itself. It drives a trial code to an external DAC and reads one comparator bit, which reports whether the DAC level is above the sampled input. On each clock it resolves one bit of the result, starting at the most significant bit and working down.

A one-cycle `start` while the controller is idle clears the running estimate and begins a conversion. Each cycle puts the highest untested bit into the trial code. On the next edge the controller reads the comparator and either drops that bit or keeps it. After exactly `NBITS` cycles the final code is loaded into the result register, which holds it until the next conversion ends, and `done` pulses once. The time taken does not depend on the input level.

Top module: `sar_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, `busy`, `done`, `result` and `trial` all become zero on that edge.
- R2: A `start` sampled high while `busy` is low clears the estimate. From the next cycle `busy` is 1 and `trial` holds only bit NBITS-1.
- R3: In each busy cycle, `trial` is the set of bits kept so far, OR'd with the highest bit not yet tested.
- R4: A comparator input `cmp_high` of 1 at the edge that ends a busy cycle drops the bit under test. A value of 0 keeps it. A DAC level equal to the input is not "above", so the bit is kept.
- R5: Bits are tested strictly from bit NBITS-1 down to bit 0, one per cycle.
- R6: `busy` stays high for exactly NBITS cycles per conversion, for every input level.
- R7: `done` is high for exactly one cycle, in the cycle right after the last busy cycle. `busy` is low in that cycle.
- R8: `result` changes only when `done` rises. It keeps its value until the next conversion completes. Outside a conversion, `trial` shows the last final estimate, or zero after reset.
- R9: A `start` sampled while `busy` is high is ignored and does not restart the conversion.
- R10: With 8 bits and an input of 153, the estimate is 0x80 after trials 1 to 3 and 0x90 after trial 4, so trial 5 drives 0x98. The result is 0x99.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Conversion request, honoured only when idle |
| cmp_high | input | 1 | 1 when the DAC level is above the analog input |
| busy | output | 1 | High while bits are being tested |
| done | output | 1 | One-cycle pulse when the result is updated |
| trial | output | NBITS | Code driven to the DAC |
| result | output | NBITS | Last completed conversion |

## Verification
The controller is exercised against a behavioural DAC/comparator model at these input levels:
- 0 and full scale, where every bit is dropped or every bit is kept.
- 153, a mixed pattern with a known trace.
- 127 and 128, which sit either side of the MSB decision.
- 1 and 254, where the decisions go the other way only at the last bit.
- 170, alternating bits.

Together these levels separate a wrong keep/drop polarity, a wrong handling of equality, and a wrong bit order. A `start` held high for a whole conversion shows that requests made while busy are ignored. Changing the input level between conversions shows that `result` holds its value until the next `done`.

// File: rtl/sar_ctrl.sv
module sar_ctrl #(
  parameter int NBITS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             cmp_high,
  output logic             busy,
  output logic             done,
  output logic [NBITS-1:0] trial,
  output logic [NBITS-1:0] result
);

  localparam logic [NBITS-1:0] TOP_BIT = {1'b1, {(NBITS-1){1'b0}}};

  logic [NBITS-1:0] est;
  logic [NBITS-1:0] probe;
  logic [NBITS-1:0] next_est;

  assign trial    = est | probe;
  assign next_est = cmp_high ? est : (est | probe);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      est    <= '0;
      probe  <= '0;
      result <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          est   <= '0;
          probe <= TOP_BIT;
          busy  <= 1'b1;
        end
      end else begin
        est   <= next_est;
        probe <= probe >> 1;
        if (probe[0]) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          result <= next_est;
        end
      end
    end
  end

endmodule

// File: rtl/sar_ctrl_chk.sv
module sar_ctrl_chk #(
  parameter int NBITS = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             cmp_high,
  input logic             busy,
  input logic             done,
  input logic [NBITS-1:0] trial,
  input logic [NBITS-1:0] result
);

  localparam logic [NBITS-1:0] TOP_BIT = {1'b1, {(NBITS-1){1'b0}}};
  localparam int CW = $clog2(NBITS + 2);

  logic [CW-1:0] run_len;

  always_ff @(posedge clk) begin
    if (rst) run_len <= '0;
    else if (!busy && start) run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
  end

  p_start_loads_msb_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> (busy && trial == TOP_BIT));

  p_drop_lowers_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && cmp_high) |=> (!busy || trial < $past(trial)));

  p_keep_raises_r3: assert property (@(posedge clk) disable iff (rst)
    (busy && !cmp_high) |=> (!busy || trial > $past(trial)));

  p_run_length_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> (run_len == CW'(NBITS)));

  p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_result_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !done |=> (done || $stable(result)));

  p_no_restart_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> (!busy || trial != TOP_BIT));

endmodule

bind sar_ctrl sar_ctrl_chk #(.NBITS(NBITS)) u_chk (.*);

// File: tb/sim_sar_ctrl.sv
module sim_sar_ctrl;
  localparam int NB = 8;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic cmp_high;
  logic busy, done;
  logic [NB-1:0] trial, result;
  int vin = 0;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  int m_busy = 0, m_bit = 0, m_est = 0, m_res = 0, m_done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign cmp_high = (int'(trial) > vin);

  sar_ctrl #(.NBITS(NB)) u0 (
    .clk(clk), .rst(rst), .start(start), .cmp_high(cmp_high),
    .busy(busy), .done(done), .trial(trial), .result(result)
  );

  function automatic int m_trial();
    return m_est | (m_busy != 0 ? (1 << m_bit) : 0);
  endfunction

  always @(posedge clk) begin
    int tr;
    tr = m_trial();
    if (rst) begin
      m_busy = 0; m_bit = 0; m_est = 0; m_res = 0; m_done = 0;
    end else begin
      m_done = 0;
      if (m_busy == 0) begin
        if (start) begin m_busy = 1; m_bit = NB - 1; m_est = 0; end
      end else begin
        if (!(tr > vin)) m_est = tr;
        if (m_bit == 0) begin m_busy = 0; m_done = 1; m_res = m_est; end
        else m_bit = m_bit - 1;
      end
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !finished) begin
      check("R6", "busy", int'(busy), m_busy);
      check("R7", "done", int'(done), m_done);
      check("R8", "result", int'(result), m_res);
      check("R3", "trial", int'(trial), m_trial());
    end
  end

  task automatic convert(input int level, input bit hold_start, output int tr5);
    int cyc;
    vin = level;
    tr5 = -1;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    if (!hold_start) start = 1'b0;
    check("R2", "trial after start", int'(trial), 1 << (NB - 1));
    cyc = 0;
    while (busy && cyc < NB + 4) begin
      cyc++;
      if (cyc == 5) tr5 = int'(trial);
      @(negedge clk);
      if (cyc == 2) start = 1'b0;
    end
    check("R6", "busy cycles", cyc, NB);
    check("R7", "done after run", int'(done), 1);
    check("R4", "result equals level", int'(result), level);
    start = 1'b0;
  endtask

  initial begin
    int t5;
    repeat (3) @(negedge clk);
    check("R1", "busy at reset", int'(busy), 0);
    check("R1", "done at reset", int'(done), 0);
    check("R1", "result at reset", int'(result), 0);
    check("R1", "trial at reset", int'(trial), 0);
    rst = 1'b0;

    convert(153, 0, t5);
    check("R10", "trial 5", t5, 8'h98);
    check("R10", "final", int'(result), 8'h99);

    convert(0, 0, t5);
    convert(255, 0, t5);
    convert(128, 0, t5);
    check("R5", "msb-only code", int'(result), 128);
    convert(127, 0, t5);
    convert(1, 0, t5);
    convert(254, 0, t5);
    convert(170, 0, t5);

    convert(77, 1, t5);
    check("R9", "held start ignored", int'(result), 77);

    vin = 200;
    repeat (5) @(negedge clk);
    check("R8", "result held while idle", int'(result), 77);
    check("R8", "trial holds last estimate", int'(trial), 77);

    repeat (2) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule